// File: doc/BRIEF.md
# Register-Bank Two-Wire Write Slave

This block is a receive-only two-wire (I2C) slave that owns a bank of nine 8-bit control registers. It watches oversampled SCL and SDA and finds bus START and STOP events. It compares the first byte of each transfer with a fixed 7-bit address plus a write bit. Each accepted byte is acknowledged by pulling SDA low through the ninth clock. The register contents are presented in parallel so that surrounding logic can use them directly.

The first data byte after the address chooses how the transfer proceeds. Two short forms load the low six bits of register 0 or register 1 in a single byte. An indexed form names a starting register. A reserved code leaves every register untouched. In every form, later bytes go to the next register in turn until STOP, and bytes past the last register are acknowledged but dropped. Three fields are decoded and brought out as pins: a 3-bit power-state field, a companion power-down bit and a voice-activity enable bit.

Top module: `twc_regs_top`

## Requirements
- R1: The slave acknowledges only the address byte 0x80 (7-bit address 1000000, write bit 0). Any other address byte gets no acknowledge, and all bytes up to the next START are then neither acknowledged nor written.
- R2: A first data byte with bits [7:6] = 00 copies bits [5:0] into register 0 bits [5:0].
- R3: A first data byte with bits [7:6] = 01 copies bits [5:0] into register 1 bits [5:0].
- R4: A first data byte with bits [7:6] = 11 sets the write pointer to bits [3:0]. The next byte is written whole to that register. An index above 8 discards the rest of the transfer.
- R5: Bits [7:6] of registers 0 and 1 are never written and always read 0, in every access form.
- R6: A first data byte with bits [7:6] = 10 changes no register for the whole transfer, although every byte is still acknowledged.
- R7: Each data byte after the first goes to the register after the previous one. After a short form on register 0 the next byte goes to register 1, and after one on register 1 it goes to register 2.
- R8: After register 8 has been written the pointer stays exhausted. Further bytes are acknowledged and discarded.
- R9: For an accepted byte, the slave holds SDA low from the SCL fall after bit 8 until the SCL fall after the ninth clock, and then releases it.
- R10: `pwr_mode_o` decodes register 6 bits [2:0]. Bit 2 = 1 gives 3 (all off). 010 gives 1 (data path only). 011 gives 2 (idle). 000 and 001 give 0 (normal).
- R11: `hpdn_o` equals register 5 bit 1 and `vox_o` equals register 8 bit 7, whatever the power state.
- R12: Synchronous reset clears every register, releases SDA and returns the receiver to idle.
- R13: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. STOP ends a transfer and releases SDA. A repeated START begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| sda_pull_o | output | 1 | 1 = drive SDA low (open-drain acknowledge) |
| regs_o | output | 72 | Register n on bits [8n+7:8n] |
| pwr_mode_o | output | 2 | Decoded power state (see R10) |
| hpdn_o | output | 1 | Register 5 bit 1 |
| vox_o | output | 1 | Register 8 bit 7 |

## Verification
The assertions check the invariant properties on every cycle. Bits [7:6] of registers 0 and 1 always read 0. The bank changes only in a cycle that follows a delivered byte. The pointer never passes its exhausted value. A STOP always releases SDA, and SDA stays released while the receiver ignores a foreign transfer. The bench scenarios are needed for everything that depends on byte order: which register a given access form lands on, how auto-increment continues from a short form, saturation past register 8, silence of the reserved code, the acknowledge pattern for a wrong address, the effect of a repeated START, and the decoded power states.

// File: rtl/twc_pkg.sv
package twc_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_ACK_WAIT,
        RX_ACK_HOLD,
        RX_IGNORE
    } rx_state_e;

    typedef enum logic [1:0] {
        AM_QUICK0  = 2'b00,
        AM_QUICK1  = 2'b01,
        AM_TEST    = 2'b10,
        AM_INDEXED = 2'b11
    } acc_mode_e;

    typedef enum logic [1:0] {
        PM_NORMAL    = 2'd0,
        PM_DATA_ONLY = 2'd1,
        PM_IDLE      = 2'd2,
        PM_OFF       = 2'd3
    } pwr_mode_e;

    typedef struct packed {
        logic       valid;
        logic       first;
        logic [7:0] data;
    } rx_byte_t;

    function automatic pwr_mode_e pwr_decode(input logic [2:0] f);
        if (f[2])
            return PM_OFF;
        else if (f[1:0] == 2'b10)
            return PM_DATA_ONLY;
        else if (f[1:0] == 2'b11)
            return PM_IDLE;
        else
            return PM_NORMAL;
    endfunction

endpackage

// File: rtl/twc_line_sync.sv
module twc_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q, scl_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twc_byte_rx.sv
module twc_byte_rx
    import twc_pkg::*;
#(
    parameter logic [6:0] ADDR7 = 7'h40
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sda_s,
    input  logic     scl_rise,
    input  logic     scl_fall,
    input  logic     start_det,
    input  logic     stop_det,
    output logic     sda_pull,
    output rx_byte_t byte_o
);
    rx_state_e  state;
    logic [2:0] bit_cnt;
    logic [6:0] shreg;
    logic       is_addr;
    logic       first_pend;
    logic [7:0] full_byte;

    assign full_byte = {shreg, sda_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= RX_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            is_addr    <= 1'b0;
            first_pend <= 1'b0;
            sda_pull   <= 1'b0;
            byte_o     <= '0;
        end else begin
            byte_o.valid <= 1'b0;
            if (start_det) begin
                state    <= RX_SHIFT;
                bit_cnt  <= '0;
                is_addr  <= 1'b1;
                sda_pull <= 1'b0;
            end else if (stop_det) begin
                state    <= RX_IDLE;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    RX_SHIFT: if (scl_rise) begin
                        shreg   <= full_byte[6:0];
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            if (is_addr) begin
                                if (full_byte == {ADDR7, 1'b0}) begin
                                    state      <= RX_ACK_WAIT;
                                    first_pend <= 1'b1;
                                end else begin
                                    state <= RX_IGNORE;
                                end
                            end else begin
                                byte_o     <= '{valid: 1'b1, first: first_pend, data: full_byte};
                                first_pend <= 1'b0;
                                state      <= RX_ACK_WAIT;
                            end
                        end
                    end
                    RX_ACK_WAIT: if (scl_fall) begin
                        sda_pull <= 1'b1;
                        state    <= RX_ACK_HOLD;
                    end
                    RX_ACK_HOLD: if (scl_fall) begin
                        sda_pull <= 1'b0;
                        state    <= RX_SHIFT;
                        bit_cnt  <= '0;
                        is_addr  <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R13: STOP always lets go of SDA
    p_release_on_stop_r13: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_pull);

    // R1: a foreign transfer never sees an acknowledge
    p_silent_when_ignoring_r1: assert property (@(posedge clk) disable iff (rst)
        (state == RX_IGNORE) |-> !sda_pull);

    // R9: acknowledge persists until an SCL fall, STOP or START
    p_ack_held_r9: assert property (@(posedge clk) disable iff (rst)
        (sda_pull && !scl_fall && !stop_det && !start_det) |=> sda_pull);

endmodule

// File: rtl/twc_reg_bank.sv
module twc_reg_bank
    import twc_pkg::*;
#(
    parameter int unsigned NREG = 9,
    parameter int unsigned DW   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  rx_byte_t             wr,
    output logic [NREG*DW-1:0]   regs_flat
);
    localparam int unsigned PTRW = $clog2(NREG + 1);
    localparam logic [PTRW-1:0] PTR_NONE = PTRW'(NREG);

    logic [DW-1:0]   regs [NREG];
    logic [PTRW-1:0] ptr;
    acc_mode_e       mode;
    logic [3:0]      idx;

    assign mode = acc_mode_e'(wr.data[7:6]);
    assign idx  = wr.data[3:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(NREG); i++) regs[i] <= '0;
            ptr <= PTR_NONE;
        end else if (wr.valid) begin
            if (wr.first) begin
                unique case (mode)
                    AM_QUICK0: begin
                        regs[0][5:0] <= wr.data[5:0];
                        ptr          <= PTRW'(1);
                    end
                    AM_QUICK1: begin
                        regs[1][5:0] <= wr.data[5:0];
                        ptr          <= PTRW'(2);
                    end
                    AM_INDEXED: ptr <= (32'(idx) < NREG) ? PTRW'(idx) : PTR_NONE;
                    default:    ptr <= PTR_NONE;
                endcase
            end else if (ptr != PTR_NONE) begin
                if (ptr < PTRW'(2))
                    regs[ptr] <= {2'b00, wr.data[5:0]};
                else
                    regs[ptr] <= wr.data;
                ptr <= ptr + PTRW'(1);
            end
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs_flat[g*DW +: DW] = regs[g];
    end

    // R5: the two top bits of registers 0 and 1 stay clear
    p_top_bits_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (regs_flat[7:6] == 2'b00) && (regs_flat[DW+7:DW+6] == 2'b00));

    // R6: the bank moves only after a delivered byte
    p_hold_without_byte_r6: assert property (@(posedge clk) disable iff (rst)
        !wr.valid |=> $stable(regs_flat));

    // R8: the pointer never runs past its exhausted value
    p_ptr_bounded_r8: assert property (@(posedge clk) disable iff (rst)
        ptr <= PTR_NONE);

endmodule

// File: rtl/twc_regs_top.sv
module twc_regs_top
    import twc_pkg::*;
#(
    parameter logic [6:0]  ADDR7       = 7'h40,
    parameter int unsigned NREG        = 9,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic [NREG*8-1:0] regs_o,
    output logic [1:0]        pwr_mode_o,
    output logic              hpdn_o,
    output logic              vox_o
);
    localparam int unsigned DW     = 8;
    localparam int unsigned R_HPDN = 5;
    localparam int unsigned R_PWR  = 6;
    localparam int unsigned R_VOX  = 8;

    logic     sda_s, scl_rise, scl_fall, start_det, stop_det;
    rx_byte_t rx_byte;

    twc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twc_byte_rx #(.ADDR7(ADDR7)) u_rx (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .sda_pull(sda_pull_o), .byte_o(rx_byte)
    );

    twc_reg_bank #(.NREG(NREG), .DW(DW)) u_bank (
        .clk(clk), .rst(rst), .wr(rx_byte), .regs_flat(regs_o)
    );

    assign pwr_mode_o = pwr_decode(regs_o[R_PWR*DW +: 3]);
    assign hpdn_o     = regs_o[R_HPDN*DW + 1];
    assign vox_o      = regs_o[R_VOX*DW + 7];

    // R12: SDA is released in the cycle after reset
    p_reset_release_r12: assert property (@(posedge clk)
        rst |=> !sda_pull_o);

endmodule

// File: tb/tb_twc_regs_top.sv
module tb_twc_regs_top;
    localparam int HALF = 12;
    localparam int QTR  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_pull_o, hpdn_o, vox_o;
    logic [71:0] regs_o;
    logic [1:0]  pwr_mode_o;
    logic sda_line;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_drv & ~sda_pull_o;

    twc_regs_top dut (
        .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_line),
        .sda_pull_o(sda_pull_o), .regs_o(regs_o), .pwr_mode_o(pwr_mode_o),
        .hpdn_o(hpdn_o), .vox_o(vox_o)
    );

    // fields: addr, d0, d1, d2, byte count, checked reg, expected value, expected ack
    localparam logic [48:0] VECS [8] = '{
        {8'h80, 8'h2A, 8'h00, 8'h00, 4'd1, 4'd0, 8'h2A, 1'b1},
        {8'h80, 8'h55, 8'h00, 8'h00, 4'd1, 4'd1, 8'h15, 1'b1},
        {8'h80, 8'hC2, 8'hA5, 8'h3C, 4'd3, 4'd3, 8'h3C, 1'b1},
        {8'h80, 8'hC0, 8'hFF, 8'hFF, 4'd3, 4'd0, 8'h3F, 1'b1},
        {8'h80, 8'h81, 8'h77, 8'h00, 4'd2, 4'd1, 8'h3F, 1'b1},
        {8'h80, 8'h0A, 8'hEE, 8'h00, 4'd2, 4'd1, 8'h2E, 1'b1},
        {8'h82, 8'hC4, 8'h99, 8'h00, 4'd2, 4'd4, 8'h00, 1'b0},
        {8'h80, 8'hC8, 8'h81, 8'h12, 4'd3, 4'd8, 8'h81, 1'b1}
    };
    string vtag [8] = '{"R2", "R3", "R4", "R5", "R6", "R7", "R1", "R8"};

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        @(negedge clk);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_drv = 1'b1; wait_clk(QTR);
        scl_drv = 1'b1; wait_clk(QTR);
        sda_drv = 1'b0; wait_clk(QTR);
        scl_drv = 1'b0; wait_clk(QTR);
    endtask

    task automatic bus_stop;
        sda_drv = 1'b0; wait_clk(QTR);
        scl_drv = 1'b1; wait_clk(QTR);
        sda_drv = 1'b1; wait_clk(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wait_clk(QTR);
            scl_drv = 1'b1; wait_clk(HALF);
            scl_drv = 1'b0; wait_clk(QTR);
        end
        sda_drv = 1'b1; wait_clk(QTR);
        scl_drv = 1'b1; wait_clk(HALF / 2);
        @(negedge clk) ack = sda_pull_o;
        wait_clk(HALF / 2);
        scl_drv = 1'b0; wait_clk(QTR);
    endtask

    task automatic write_reg(input logic [3:0] idx, input logic [7:0] val);
        logic a;
        bus_start;
        send_byte(8'h80, a);
        send_byte({4'hC, idx}, a);
        send_byte(val, a);
        bus_stop;
    endtask

    initial begin
        wait_clk(150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [48:0] e;
        logic a;
        wait_clk(4);
        rst = 1'b0;
        wait_clk(4);
        // R12: reset state
        check("R12 regs", 32'(regs_o == '0), 32'd1);
        check("R12 sda", 32'(sda_pull_o), 32'd0);
        check("R10 reset mode", 32'(pwr_mode_o), 32'd0);

        for (int v = 0; v < 8; v++) begin
            e = VECS[v];
            bus_start;
            send_byte(e[48:41], a);
            check({vtag[v], " addr ack"}, 32'(a), 32'(e[0]));
            for (int k = 0; k < int'(e[16:13]); k++) begin
                send_byte(e[40 - 8*k -: 8], a);
                check({vtag[v], " data ack"}, 32'(a), 32'(e[0]));
            end
            // R9: pull released after the ninth clock
            check("R9 release", 32'(sda_pull_o), 32'd0);
            bus_stop;
            check({vtag[v], " reg"}, 32'(regs_o[8*int'(e[12:9]) +: 8]), 32'(e[8:1]));
        end
        // R4 / R7 side results of vectors
        check("R4 reg2", 32'(regs_o[16 +: 8]), 32'hA5);
        check("R11 vox", 32'(vox_o), 32'd1);

        // R13: repeated START starts a fresh address phase
        bus_start;
        send_byte(8'h80, a); send_byte(8'hC7, a); send_byte(8'h11, a);
        bus_start;
        send_byte(8'h80, a);
        check("R13 restart ack", 32'(a), 32'd1);
        send_byte(8'hC4, a); send_byte(8'h22, a);
        bus_stop;
        check("R13 reg7", 32'(regs_o[56 +: 8]), 32'h11);
        check("R13 reg4", 32'(regs_o[32 +: 8]), 32'h22);
        check("R13 sda idle", 32'(sda_pull_o), 32'd0);

        // R10 / R11: power decode and mirrored pins
        write_reg(4'd5, 8'h02);
        check("R11 hpdn", 32'(hpdn_o), 32'd1);
        write_reg(4'd6, 8'h04);
        check("R10 off", 32'(pwr_mode_o), 32'd3);
        check("R11 hpdn in off", 32'(hpdn_o), 32'd1);
        write_reg(4'd6, 8'h02);
        check("R10 data only", 32'(pwr_mode_o), 32'd1);
        write_reg(4'd6, 8'h03);
        check("R10 idle", 32'(pwr_mode_o), 32'd2);
        write_reg(4'd6, 8'h07);
        check("R10 off 111", 32'(pwr_mode_o), 32'd3);
        write_reg(4'd6, 8'h01);
        check("R10 normal 001", 32'(pwr_mode_o), 32'd0);
        write_reg(4'd5, 8'hFD);
        check("R11 hpdn clear", 32'(hpdn_o), 32'd0);

        // R4: index above 8 discards
        bus_start;
        send_byte(8'h80, a); send_byte(8'hCB, a); send_byte(8'h5A, a);
        bus_stop;
        check("R4 bad index ack", 32'(a), 32'd1);
        check("R4 bad index reg0", 32'(regs_o[0 +: 8]), 32'h0A);

        // R12: reset after activity
        rst = 1'b1; wait_clk(2); rst = 1'b0; wait_clk(1);
        check("R12 regs after reset", 32'(regs_o == '0), 32'd1);
        check("R12 vox after reset", 32'(vox_o), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule